// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block walks a DDR SDRAM device through its power-up setup on a single-phase command bus. The bus carries clock enable, active-low chip select, RAS, CAS and write enable, a row/column address and a bank address. A one-cycle start pulse launches the run. The block first raises clock enable. It then performs the two-stage mode setup:

- a precharge of all banks;
- a load of the extended mode register;
- a mode register load that resets the DLL;
- a second precharge of all banks;
- two auto-refresh commands;
- a final mode register load that leaves the DLL running.

The run ends by opening row 0 of bank 0. After the last wait, a done flag rises.

Each command occupies exactly one cycle. Every cycle that is not a command cycle shows the deselect level: all four strobes high, and address and bank zero. The pauses between commands come from one shared down-counter. There are four wait classes, each a parameter in clock cycles:

- a short gap after clock enable, after each precharge and after the extended load;
- a long settle after each mode register load;
- a refresh recovery after each refresh;
- an activation wait after the final activate.

A start received while the run is in progress is ignored. A start received after done reruns the whole sequence.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is held, and in the idle state after it, cke is 0, cs_n, ras_n, cas_n and we_n are all 1, addr and ba are 0, and done is 0. Reset is synchronous and active high.
- R2: A start pulse taken in idle makes cke 1 in the next cycle. That cycle issues no command (all strobes 1, addr 0, ba 0). Once raised, cke stays 1 until reset.
- R3: The strobe cycles come in this fixed order. The strobe tuple is {cs_n,ras_n,cas_n,we_n}:
  - precharge-all, 0010;
  - extended mode load, 0000;
  - mode load, 0000;
  - precharge-all, 0010;
  - refresh, 0001;
  - refresh, 0001;
  - mode load, 0000;
  - activate, 0011.
  That makes eight commands per run.
- R4: Each command cycle carries its own address and bank:
  - each precharge: addr 0x0400 (bit 10 set), ba 0;
  - extended load: addr 0x0000, ba 1;
  - first mode load: addr 0x0132 (DLL reset, CAS latency 3, burst 4), ba 0;
  - refresh: addr 0, ba 0;
  - final mode load: addr 0x0032, ba 0;
  - activate: addr 0, ba 0.
- R5: The number of deselect cycles that follow each command cycle depends on the command:
  - T_GAP after the clock-enable cycle, after each precharge and after the extended load;
  - T_DLL after each mode load;
  - T_REF after each refresh;
  - T_ACT after the activate.
  The distance between two consecutive strobes is therefore the wait plus one.
- R6: Every strobe is low for one cycle only. In every cycle without a command, all four strobes are 1 and addr and ba are 0.
- R7: done goes to 1 in the cycle after the last T_ACT wait cycle. It stays 1, with the bus at deselect and cke at 1, until reset or a new start.
- R8: A start pulse received while the sequence is running has no effect on the bus timing or the command order.
- R9: A start received while done is 1 clears done in the next cycle and reruns the full sequence, with cke held at 1 throughout.
- R10: Reset asserted in the middle of a run returns the block to the R1 idle state in the next cycle. A later start runs the full sequence from the beginning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run the sequence |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Row/column address (default 13 bits) |
| ba | output | BA_W | Bank address (default 2 bits) |
| done | output | 1 | Sequence complete, held until reset or restart |

## Verification
The bench builds the block with T_GAP=2, T_DLL=9, T_REF=3 and T_ACT=5 instead of the long defaults. With these values a full run lasts under fifty cycles, so several complete runs fit in one session: back-to-back restarts, a run with start held high throughout, and a reset in the middle of a run. Because the four wait classes have different lengths, a command that is followed by the wrong class shows up as a wrong strobe distance. So does a counter that is off by one.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   // Internal command word, active high: {cs, ras, cas, we}
   typedef struct packed {
      logic cs;
      logic ras;
      logic cas;
      logic we;
   } ddr_cmd_t;

   localparam ddr_cmd_t CMD_NONE = 4'b0000;
   localparam ddr_cmd_t CMD_PREA = 4'b1101;
   localparam ddr_cmd_t CMD_MRS  = 4'b1111;
   localparam ddr_cmd_t CMD_REF  = 4'b1110;
   localparam ddr_cmd_t CMD_ACT  = 4'b1100;

   typedef enum logic [1:0] {
      WAIT_GAP,
      WAIT_DLL,
      WAIT_REF,
      WAIT_ACT
   } wait_cls_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CMD,
      PH_WAIT,
      PH_DONE
   } phase_e;

   // clock enable, 2x precharge, ext load, 2x mode load, 2x refresh, activate
   localparam int NUM_STEPS = 9;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int BA_W       = 2,
   parameter int STEP_W     = 4,
   parameter int AP_BIT     = 10,
   parameter int MR_DLL_RST = 'h132,
   parameter int MR_RUN     = 'h032,
   parameter int EMR_BANK   = 1
) (
   input  logic [STEP_W-1:0] step,
   output ddr_cmd_t          cmd,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output wait_cls_e         wcls
);

   localparam logic [ADDR_W-1:0] A_PREA  = ADDR_W'(1) << AP_BIT;
   localparam logic [ADDR_W-1:0] A_MRDLL = ADDR_W'(MR_DLL_RST);
   localparam logic [ADDR_W-1:0] A_MRRUN = ADDR_W'(MR_RUN);
   localparam logic [BA_W-1:0]   B_EMR   = BA_W'(EMR_BANK);

   always_comb begin
      cmd  = CMD_NONE;
      addr = '0;
      ba   = '0;
      wcls = WAIT_GAP;
      case (step)
         STEP_W'(0): begin                      // raise clock enable only
            cmd  = CMD_NONE;
            wcls = WAIT_GAP;
         end
         STEP_W'(1), STEP_W'(4): begin          // precharge all banks
            cmd  = CMD_PREA;
            addr = A_PREA;
            wcls = WAIT_GAP;
         end
         STEP_W'(2): begin                      // extended mode load
            cmd  = CMD_MRS;
            ba   = B_EMR;
            wcls = WAIT_GAP;
         end
         STEP_W'(3): begin                      // mode load, DLL reset
            cmd  = CMD_MRS;
            addr = A_MRDLL;
            wcls = WAIT_DLL;
         end
         STEP_W'(5), STEP_W'(6): begin          // auto refresh
            cmd  = CMD_REF;
            wcls = WAIT_REF;
         end
         STEP_W'(7): begin                      // mode load, DLL running
            cmd  = CMD_MRS;
            addr = A_MRRUN;
            wcls = WAIT_DLL;
         end
         STEP_W'(8): begin                      // open row 0, bank 0
            cmd  = CMD_ACT;
            wcls = WAIT_ACT;
         end
         default: begin
            cmd  = CMD_NONE;
            wcls = WAIT_GAP;
         end
      endcase
   end

endmodule

// File: rtl/ddr_init_wait_ctr.sv
module ddr_init_wait_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // R5: an exhausted wait never wraps around to a fresh count unless reloaded
   assert_no_wrap_R5 : assert property (@(posedge clk) disable iff (rst)
      (expired && !load) |=> expired);

endmodule

// File: rtl/ddr_init_cmd_drive.sv
module ddr_init_cmd_drive
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2
) (
   input  logic              issue,
   input  ddr_cmd_t          cmd,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [BA_W-1:0]   ba_in,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba
);

   localparam int NSTROBE = 4;

   logic [NSTROBE-1:0] cmd_bits;
   logic [NSTROBE-1:0] strobe_n;

   assign cmd_bits = cmd;

   for (genvar i = 0; i < NSTROBE; i++) begin : g_strobe
      assign strobe_n[i] = ~(issue & cmd_bits[i]);
   end

   assign cs_n  = strobe_n[3];
   assign ras_n = strobe_n[2];
   assign cas_n = strobe_n[1];
   assign we_n  = strobe_n[0];

   assign addr = issue ? addr_in : '0;
   assign ba   = issue ? ba_in   : '0;

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int BA_W       = 2,
   parameter int AP_BIT     = 10,
   parameter int MR_DLL_RST = 'h132,
   parameter int MR_RUN     = 'h032,
   parameter int EMR_BANK   = 1,
   parameter int T_GAP      = 2,
   parameter int T_DLL      = 200,
   parameter int T_REF      = 4,
   parameter int T_ACT      = 15
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [ADDR_W-1:0] addr,
   output logic [BA_W-1:0]   ba,
   output logic              done
);

   localparam int STEP_W = $clog2(NUM_STEPS);
   localparam int MAX_W  = max_of(max_of(T_GAP, T_DLL), max_of(T_REF, T_ACT));
   localparam int CNT_W  = (MAX_W > 1) ? $clog2(MAX_W) : 1;
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

   // elaboration-time parameter checks
   if (ADDR_W <= AP_BIT) begin : g_chk_ap
      $error("ddr_init_seq: ADDR_W must exceed AP_BIT");
   end
   if (MR_DLL_RST >= (1 << ADDR_W) || MR_RUN >= (1 << ADDR_W)) begin : g_chk_mr
      $error("ddr_init_seq: mode values do not fit ADDR_W");
   end
   if (EMR_BANK >= (1 << BA_W)) begin : g_chk_ba
      $error("ddr_init_seq: EMR_BANK does not fit BA_W");
   end
   if (T_GAP < 1 || T_DLL < 1 || T_REF < 1 || T_ACT < 1) begin : g_chk_wait
      $error("ddr_init_seq: every wait must be at least one cycle");
   end

   phase_e            phase_q;
   logic [STEP_W-1:0] step_q;
   logic              cke_q;

   ddr_cmd_t          rom_cmd;
   logic [ADDR_W-1:0] rom_addr;
   logic [BA_W-1:0]   rom_ba;
   wait_cls_e         rom_wcls;

   int                wait_len;
   logic [CNT_W-1:0]  load_val;
   logic              ctr_load;
   logic              expired;
   logic              issue;

   ddr_init_step_rom #(
      .ADDR_W     (ADDR_W),
      .BA_W       (BA_W),
      .STEP_W     (STEP_W),
      .AP_BIT     (AP_BIT),
      .MR_DLL_RST (MR_DLL_RST),
      .MR_RUN     (MR_RUN),
      .EMR_BANK   (EMR_BANK)
   ) u_rom (
      .step (step_q),
      .cmd  (rom_cmd),
      .addr (rom_addr),
      .ba   (rom_ba),
      .wcls (rom_wcls)
   );

   always_comb begin
      case (rom_wcls)
         WAIT_DLL: wait_len = T_DLL;
         WAIT_REF: wait_len = T_REF;
         WAIT_ACT: wait_len = T_ACT;
         default:  wait_len = T_GAP;
      endcase
   end

   assign load_val = CNT_W'(wait_len - 1);
   assign ctr_load = (phase_q == PH_CMD);

   ddr_init_wait_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (ctr_load),
      .load_val (load_val),
      .expired  (expired)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         step_q  <= '0;
         cke_q   <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE, PH_DONE: begin
               if (start) begin
                  phase_q <= PH_CMD;
                  step_q  <= '0;
                  cke_q   <= 1'b1;
               end
            end
            PH_CMD: phase_q <= PH_WAIT;
            PH_WAIT: begin
               if (expired) begin
                  if (step_q == LAST_STEP) begin
                     phase_q <= PH_DONE;
                  end else begin
                     step_q  <= step_q + 1'b1;
                     phase_q <= PH_CMD;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign issue = (phase_q == PH_CMD);

   ddr_init_cmd_drive #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W)
   ) u_drive (
      .issue   (issue),
      .cmd     (rom_cmd),
      .addr_in (rom_addr),
      .ba_in   (rom_ba),
      .cs_n    (cs_n),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n),
      .addr    (addr),
      .ba      (ba)
   );

   assign cke  = cke_q;
   assign done = (phase_q == PH_DONE);

   // R2: clock enable never drops without reset
   assert_cke_hold_R2 : assert property (@(posedge clk) disable iff (rst)
      cke |=> cke);

   // R6: a selected cycle is always followed by a deselect cycle
   assert_single_strobe_R6 : assert property (@(posedge clk) disable iff (rst)
      !cs_n |=> (cs_n && ras_n && cas_n && we_n));

   // R6: address and bank are quiet whenever the chip is deselected
   assert_quiet_bus_R6 : assert property (@(posedge clk) disable iff (rst)
      cs_n |-> (addr == '0 && ba == '0));

   // R4: refresh cycles carry a zero address and bank
   assert_ref_addr_R4 : assert property (@(posedge clk) disable iff (rst)
      (!cs_n && !ras_n && !cas_n && we_n) |-> (addr == '0 && ba == '0));

   // R7: after completion the bus rests at deselect with the clock enabled
   assert_done_idle_R7 : assert property (@(posedge clk) disable iff (rst)
      done |-> (cke && cs_n && ras_n && cas_n && we_n));

   // R8: a start during an unfinished wait leaves the step and phase alone
   assert_ignore_start_R8 : assert property (@(posedge clk) disable iff (rst)
      (phase_q == PH_WAIT && !expired && start) |=> (phase_q == PH_WAIT && $stable(step_q)));

endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

   localparam int AW = 13;
   localparam int BW = 2;
   localparam int G  = 2;
   localparam int D  = 9;
   localparam int RF = 3;
   localparam int A  = 5;

   typedef struct packed {
      logic [3:0]    cmdn;   // {cs_n, ras_n, cas_n, we_n}
      logic [AW-1:0] a;
      logic [BW-1:0] b;
   } ent_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic          cke, cs_n, ras_n, cas_n, we_n, done;
   logic [AW-1:0] addr;
   logic [BW-1:0] ba;

   always #10 clk = ~clk;   // 50 MHz

   ddr_init_seq #(
      .T_GAP (G),
      .T_DLL (D),
      .T_REF (RF),
      .T_ACT (A)
   ) uut (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .addr  (addr),
      .ba    (ba),
      .done  (done)
   );

   int    vectors = 0;
   int    miscompares = 0;
   int    cyc = 0;
   bit    finished = 0;

   // reference model state
   ent_t  exp_q[$];
   string tag_q[$];
   ent_t  cur;
   string cur_tag = "R1";
   logic  m_cke = 1'b0;
   logic  m_done = 1'b0;
   bit    m_running = 0;
   int    strobe_cyc[$];

   localparam ent_t IDLE_E = '{cmdn: 4'b1111, a: '0, b: '0};

   task automatic push(input logic [3:0] c, input int a, input int b, input string t);
      exp_q.push_back('{cmdn: c, a: AW'(a), b: BW'(b)});
      tag_q.push_back(t);
   endtask

   task automatic push_nops(input int n, input string t);
      for (int i = 0; i < n; i++) push(4'b1111, 0, 0, t);
   endtask

   task automatic build_run();
      push(4'b1111, 0, 0, "R2");
      push_nops(G, "R5");
      push(4'b0010, 'h400, 0, "R3");     // precharge all
      push_nops(G, "R5");
      push(4'b0000, 0, 1, "R4");         // extended mode load
      push_nops(G, "R5");
      push(4'b0000, 'h132, 0, "R4");     // mode load, DLL reset
      push_nops(D, "R5");
      push(4'b0010, 'h400, 0, "R3");     // precharge all
      push_nops(G, "R5");
      push(4'b0001, 0, 0, "R3");         // refresh
      push_nops(RF, "R5");
      push(4'b0001, 0, 0, "R3");         // refresh
      push_nops(RF, "R5");
      push(4'b0000, 'h032, 0, "R4");     // final mode load
      push_nops(D, "R5");
      push(4'b0011, 0, 0, "R3");         // activate
      push_nops(A, "R5");
   endtask

   task automatic model_edge(input logic s, input logic r);
      cyc++;
      if (r) begin
         exp_q.delete();
         tag_q.delete();
         m_cke = 0; m_done = 0; m_running = 0;
         cur = IDLE_E; cur_tag = "R10";
      end else if (exp_q.size() > 0) begin
         cur = exp_q.pop_front(); cur_tag = tag_q.pop_front();
         if (s) cur_tag = {cur_tag, "/R8"};
      end else if (m_running) begin
         m_running = 0; m_done = 1;
         cur = IDLE_E; cur_tag = "R7";
      end else if (s) begin
         build_run();
         m_running = 1; m_done = 0; m_cke = 1;
         cur = exp_q.pop_front(); cur_tag = tag_q.pop_front();
         cur_tag = {cur_tag, "/R9"};
      end else begin
         cur = IDLE_E;
         cur_tag = m_done ? "R7" : "R1";
      end
   endtask

   task automatic compare();
      logic [3:0] act_cmd;
      act_cmd = {cs_n, ras_n, cas_n, we_n};
      vectors++;
      if (act_cmd !== cur.cmdn || addr !== cur.a || ba !== cur.b ||
          cke !== m_cke || done !== m_done) begin
         miscompares++;
         $display("FAIL %s cyc %0d: actual cke=%b cmd=%b addr=%h ba=%h done=%b expected cke=%b cmd=%b addr=%h ba=%h done=%b",
                  cur_tag, cyc, cke, act_cmd, addr, ba, done,
                  m_cke, cur.cmdn, cur.a, cur.b, m_done);
      end
      if (cs_n === 1'b0) strobe_cyc.push_back(cyc);
   endtask

   task automatic step(input logic s, input logic r);
      start = s;
      rst   = r;
      @(posedge clk);
      model_edge(s, r);
      @(negedge clk);
      compare();
   endtask

   task automatic check_int(input string t, input int act, input int expv);
      vectors++;
      if (act != expv) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d", t, act, expv);
      end
   endtask

   // strobe distances over one run: R5 via ports
   task automatic check_gaps();
      int expd[7];
      expd = '{G + 1, G + 1, D + 1, G + 1, RF + 1, RF + 1, D + 1};
      check_int("R3 command count", strobe_cyc.size(), 8);
      if (strobe_cyc.size() == 8) begin
         for (int i = 0; i < 7; i++)
            check_int("R5 strobe distance", strobe_cyc[i + 1] - strobe_cyc[i], expd[i]);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      cur = IDLE_E;
      @(negedge clk);
      // R1: reset state
      for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);

      // R2..R7: full run, with stray starts during it (R8)
      strobe_cyc.delete();
      step(1'b1, 1'b0);
      for (int i = 0; i < 55; i++) step((i == 3 || i == 12 || i == 30), 1'b0);
      check_gaps();

      // R7: done holds
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0);

      // R9: restart from done
      strobe_cyc.delete();
      step(1'b1, 1'b0);
      for (int i = 0; i < 55; i++) step(1'b0, 1'b0);
      check_gaps();

      // R8/R9: start held high for an entire run and beyond
      for (int i = 0; i < 100; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);

      // R10: reset in the middle of a run, then a clean run
      step(1'b0, 1'b1);
      step(1'b1, 1'b0);
      for (int i = 0; i < 14; i++) step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
      strobe_cyc.delete();
      step(1'b1, 1'b0);
      for (int i = 0; i < 55; i++) step(1'b0, 1'b0);
      check_gaps();

      finished = 1;
      finish_run();
   end

endmodule